// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is a wide synchronous up-counter built from identical four-bit stages. Each stage counts in binary and can be preset in parallel on a clock edge. An active-low clear zeroes every stage at once, without waiting for the clock. All stages share one clock, one clear and one load strobe, so the whole word changes on the same edge.

Counting is gated by two enables. The count enable only permits an increment. The chain enable also permits an increment, and it is the only enable that enters a stage's combinational carry. Inside the wrapper, each stage's carry drives the chain enable of the next stage up. This gives a lookahead-style chain with no extra register delay between nibbles. The carry of the top stage is brought out as the terminal count, which software-free logic around the block can use to extend the chain further.

The number of stages is set by a parameter. The preset bus is split into consecutive nibbles, with the least significant nibble going to stage 0.

Top module: `chain_counter`

## Requirements
- R1: While `clear_n` is low, `count` is all zeros at once, with no clock edge needed. This overrides load and both enables.
- R2: With `clear_n` high and `load_n` low, a rising clock edge copies `preset` into `count`, whatever the levels of `cnt_en` and `chain_en`.
- R3: With `clear_n` and `load_n` high and both enables high, a rising clock edge adds one to the full-width `count`. A nibble that is all ones passes its carry into the next nibble on the same edge.
- R4: With `clear_n` and `load_n` high and either enable low, `count` keeps its value across clock edges.
- R5: `term_carry` is high exactly when `chain_en` is high and every bit of `count` is one. It does not depend on `cnt_en`, and a change on `chain_en` shows on `term_carry` in the same cycle.
- R6: Counting from all ones gives all zeros on the next edge.
- R7: `preset` bits [4k+3:4k] land in stage k, so stage 0 holds the least significant nibble of `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by every stage |
| clear_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count-only enable, fed to every stage |
| chain_en | input | 1 | Carry-propagating enable of stage 0 |
| preset | input | 4*STAGES | Parallel preset value |
| count | output | 4*STAGES | Current count |
| term_carry | output | 1 | Terminal carry: chain_en AND all count bits |

## Verification
The bench builds the block with STAGES set to 2, which gives an eight-bit counter. With that width, the full-word wrap from 0xFF to 0x00 and the carry from the low nibble into the high nibble both fall within a few cycles of a preset. That keeps the reference sequence (preset near the top, count through the wrap, then inhibit) short. The random phase also passes the terminal-carry condition and nibble boundaries many times within a few hundred cycles.

// File: rtl/chain_counter_pkg.sv
package chain_counter_pkg;
    localparam int NIB_W = 4;

    typedef logic [NIB_W-1:0] nib_t;

    typedef struct packed {
        nib_t val;
    } nib_state_t;
endpackage

// File: rtl/nib_stage.sv
module nib_stage
    import chain_counter_pkg::*;
(
    input  logic clk,
    input  logic clear_n,
    input  logic load_n,
    input  logic cnt_en,
    input  logic chain_en,
    input  nib_t preset,
    output nib_t value,
    output logic carry
);
    nib_state_t st_d;
    nib_state_t st_q;

    // Next-state: load has priority over counting; hold otherwise.
    always_comb begin
        st_d = st_q;
        if (!load_n) begin
            st_d.val = preset;
        end else if (cnt_en && chain_en) begin
            st_d.val = st_q.val + nib_t'(1);
        end
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.val;
    // Carry uses only the chain enable, never the count-only enable.
    assign carry = chain_en & (&st_q.val);
endmodule

// File: rtl/chain_counter.sv
module chain_counter
    import chain_counter_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic                    clk,
    input  logic                    clear_n,
    input  logic                    load_n,
    input  logic                    cnt_en,
    input  logic                    chain_en,
    input  logic [NIB_W*STAGES-1:0] preset,
    output logic [NIB_W*STAGES-1:0] count,
    output logic                    term_carry
);
    localparam int W = NIB_W * STAGES;

    logic [STAGES:0] link;

    assign link[0] = chain_en;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        nib_stage u_nib (
            .clk      (clk),
            .clear_n  (clear_n),
            .load_n   (load_n),
            .cnt_en   (cnt_en),
            .chain_en (link[k]),
            .preset   (preset[k*NIB_W +: NIB_W]),
            .value    (count[k*NIB_W +: NIB_W]),
            .carry    (link[k+1])
        );
    end

    assign term_carry = link[STAGES];

    logic [W-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/chain_counter_chk.sv
module chain_counter_chk #(
    parameter int STAGES = 4
) (
    input logic                  clk,
    input logic                  clear_n,
    input logic                  load_n,
    input logic                  cnt_en,
    input logic                  chain_en,
    input logic [4*STAGES-1:0]   preset,
    input logic [4*STAGES-1:0]   count,
    input logic                  term_carry
);
    localparam int W = 4 * STAGES;

    // R1: held clear gives zero count
    a_r1_clear_zero: assert property (@(posedge clk) disable iff (clear_n)
        count == '0);

    // R2, R7: load copies preset, enables ignored
    a_r2_load: assert property (@(posedge clk) disable iff (!clear_n)
        !load_n |=> count == $past(preset));

    // R3, R6: increment with wrap
    a_r3_increment: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && cnt_en && chain_en) |=> count == W'($past(count) + 1'b1));

    // R4: hold when an enable is low
    a_r4_hold: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(cnt_en && chain_en)) |=> $stable(count));

    // R5: terminal carry from chain enable and all-ones count
    a_r5_carry: assert property (@(posedge clk) disable iff (!clear_n)
        term_carry == (chain_en && (count == {W{1'b1}})));
endmodule

bind chain_counter chain_counter_chk #(.STAGES(STAGES)) u_chk (
    .clk        (clk),
    .clear_n    (clear_n),
    .load_n     (load_n),
    .cnt_en     (cnt_en),
    .chain_en   (chain_en),
    .preset     (preset),
    .count      (count),
    .term_carry (term_carry)
);

// File: tb/sim_chain_counter.sv
module sim_chain_counter;
    localparam int STAGES = 2;
    localparam int W = 4 * STAGES;

    logic         clk = 1'b0;
    logic         clear_n = 1'b0;
    logic         load_n = 1'b1;
    logic         cnt_en = 1'b0;
    logic         chain_en = 1'b0;
    logic [W-1:0] preset = '0;
    logic [W-1:0] count;
    logic         term_carry;

    int checks = 0;
    int errors = 0;
    bit reported = 0;
    logic [W-1:0] model = '0;

    chain_counter #(.STAGES(STAGES)) u0 (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .preset(preset), .count(count), .term_carry(term_carry)
    );

    always #4 clk = ~clk;

    function automatic logic [W-1:0] next_f(logic [W-1:0] cur, logic ld_n,
                                            logic ce, logic he, logic [W-1:0] p);
        if (!ld_n) return p;
        if (ce && he) return cur + 1'b1;
        return cur;
    endfunction

    function automatic logic carry_f(logic [W-1:0] cur, logic he);
        return he && (cur == {W{1'b1}});
    endfunction

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    endtask

    // Starts and ends just after a falling edge.
    task automatic step(input logic ld_n, input logic ce, input logic he,
                        input logic [W-1:0] p, input string req);
        load_n = ld_n; cnt_en = ce; chain_en = he; preset = p;
        #1;
        check(W'(term_carry), W'(carry_f(model, he)), "R5 carry");
        model = next_f(model, ld_n, ce, he, p);
        @(negedge clk);
        check(count, model, req);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        report();
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        check(count, '0, "R1 reset state");
        clear_n = 1'b1;
        model = '0;
        @(negedge clk);

        // Reference sequence: preset near top, count through wrap, inhibit
        step(1'b0, 1'b0, 1'b0, 8'hFC, "R2 load with enables low");
        step(1'b1, 1'b1, 1'b1, '0, "R3 count");
        step(1'b1, 1'b1, 1'b1, '0, "R3 count");
        step(1'b1, 1'b1, 1'b1, '0, "R3 count to all ones");
        step(1'b1, 1'b1, 1'b1, '0, "R6 wrap to zero");
        step(1'b1, 1'b1, 1'b1, '0, "R3 count");
        step(1'b1, 1'b1, 1'b1, '0, "R3 count");
        step(1'b1, 1'b0, 1'b1, '0, "R4 inhibit count enable");
        step(1'b1, 1'b1, 1'b0, '0, "R4 inhibit chain enable");

        // Nibble order and inner carry
        step(1'b0, 1'b1, 1'b1, 8'h3A, "R7 nibble order");
        step(1'b0, 1'b1, 1'b1, 8'h0F, "R2 load beats count");
        step(1'b1, 1'b1, 1'b1, '0, "R3 inner nibble carry");

        // Terminal carry independent of cnt_en; same-cycle on chain_en
        step(1'b0, 1'b0, 1'b0, 8'hFF, "R2 load all ones");
        step(1'b1, 1'b0, 1'b1, '0, "R5 hold at all ones, carry high");
        step(1'b1, 1'b0, 1'b0, '0, "R5 chain low, carry low");

        // Asynchronous clear mid-cycle
        #1;
        clear_n = 1'b0;
        #1;
        check(count, '0, "R1 clear without edge");
        model = '0;
        load_n = 1'b0; cnt_en = 1'b1; chain_en = 1'b1; preset = 8'h55;
        @(negedge clk);
        check(count, '0, "R1 clear overrides load");
        clear_n = 1'b1;
        step(1'b1, 1'b1, 1'b1, '0, "R3 count after clear");

        // Random phase
        for (int i = 0; i < 400; i++) begin
            logic ld_n, ce, he;
            logic [W-1:0] p;
            ld_n = ($urandom % 8) != 0;
            ce   = ($urandom % 4) != 0;
            he   = ($urandom % 4) != 0;
            p    = W'($urandom);
            if (($urandom % 16) == 0) p = 8'hFD;
            step(ld_n, ce, he, p, "R3/R4 random");
        end
        report();
    end
endmodule